// File: doc/BRIEF.md
# Memory Size Probe Engine

The engine discovers how much working RAM answers behind a word-addressed memory master port. After a start pulse it latches a base word address and walks a sequence of probe offsets that begins one mebibyte above the base and doubles on every passing step. It stops when the next doubling would reach the configured maximum. Each step plants the probe offset's word index at the probe location and a zero at the base. It then reads both back, so a memory that wraps, or whose address lines are shorted, shows up as the two locations aliasing. Every word the engine disturbs is written back with the value it held before the step.

The result is a byte count: zero when the memory is broken or smaller than the first probe offset, the first offset that aliased, or the full configured maximum when nothing aliased. It appears on `size_bytes` in the same cycle as a one-cycle `done` pulse and holds there until the next run finishes.

The memory side is a request/ready handshake. `mem_req` acts as the valid. While it is high and `mem_ready` is low, the engine holds the request, direction, address and write data unchanged. The memory applies back-pressure simply by keeping `mem_ready` low. An access completes in the cycle where both are high; for a read, `mem_rdata` is taken in that same cycle. Only one access is ever outstanding.

Top module: `msize_probe`

## Requirements
- R1: A start pulse seen while idle begins probing at an offset of 1 MiB expressed in words (2^18 words for 32-bit words). `mem_addr` is a word address. Each step performs, in this order: read probe word, read base word, write the probe offset (in words) to the probe address, write zero to the base address, read the base address. If that last read is zero, the step continues with two reads of the probe address, then writes the saved probe word and then the saved base word.
- R2: If the base readback after the zero write is nonzero, the engine skips the probe reads, writes the saved probe word and then the saved base word, and reports a size of 0.
- R3: If the second probe readback differs from the written index, the reported size is the probe offset in bytes, except on the first step, where it is 0. The first probe readback is ignored.
- R4: The offset doubles after each passing step. Offsets are probed only while they stay below the maximum, and when all steps pass the reported size equals MAX_BYTES.
- R5: Every run leaves the memory contents as they were before it, because each step writes back the two saved words.
- R6: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. `mem_rdata` is used only in a cycle with both high.
- R7: `done` is high for exactly one cycle, with `mem_req` low. `size_bytes` changes only in a `done` cycle and otherwise keeps its value.
- R8: `start` is ignored unless the engine is idle, including during a probe and in the `done` cycle itself.
- R9: During and right after reset, `mem_req` and `done` are low and `size_bytes` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a probe run |
| base_addr | input | ADDR_W | Base word address, latched at start |
| mem_req | output | 1 | Memory access request (valid) |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in a cycle with mem_req and mem_ready high |
| done | output | 1 | One-cycle completion pulse |
| size_bytes | output | $clog2(MAX_BYTES)+1 | Detected size in bytes |

## Verification
Two events can land on the same clock. One is a fresh `start` arriving in the very cycle that `done` is raised. The other is back-pressure stalling the final write-back of a step exactly when the step's verdict is due. The bench provokes the first by driving `start` on the edge that samples the `done` cycle, then watches that no request and no second `done` follow. It provokes the second with a pseudo-random `mem_ready` that stalls restore writes. Every accepted access is judged against a behavioural reference sequence, and the memory is compared with its initial image after each run.

// File: rtl/msp_pkg.sv
package msp_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SAVE_P,
    PH_SAVE_B,
    PH_MARK_P,
    PH_CLEAR_B,
    PH_TEST_B,
    PH_READ_P1,
    PH_READ_P2,
    PH_REST_P,
    PH_REST_B,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/msp_offset_ctr.sv
module msp_offset_ctr #(
  parameter int OFF_W       = 23,
  parameter int START_WORDS = 262144,
  parameter int MAX_WORDS   = 4194304
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  output logic [OFF_W-1:0] offset,
  output logic             first,
  output logic             last
);
  localparam logic [OFF_W-1:0] OFF_START = OFF_W'(START_WORDS);
  localparam logic [OFF_W-1:0] OFF_LAST  = OFF_W'(MAX_WORDS / 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset <= OFF_START;
    end else if (load) begin
      offset <= OFF_START;
    end else if (advance) begin
      offset <= {offset[OFF_W-2:0], 1'b0};
    end
  end

  assign first = (offset == OFF_START);
  assign last  = (offset == OFF_LAST);
endmodule

// File: rtl/msp_port_drv.sv
module msp_port_drv import msp_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 23
) (
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] keep_p,
  input  logic [DATA_W-1:0] keep_b,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  logic [ADDR_W-1:0] probe_addr;
  assign probe_addr = base + ADDR_W'(offset);

  always_comb begin
    req   = 1'b1;
    we    = 1'b0;
    addr  = base;
    wdata = '0;
    unique case (phase)
      PH_SAVE_P, PH_READ_P1, PH_READ_P2: addr = probe_addr;
      PH_SAVE_B, PH_TEST_B:              addr = base;
      PH_MARK_P: begin
        we    = 1'b1;
        addr  = probe_addr;
        wdata = DATA_W'(offset);
      end
      PH_CLEAR_B: begin
        we    = 1'b1;
        addr  = base;
        wdata = '0;
      end
      PH_REST_P: begin
        we    = 1'b1;
        addr  = probe_addr;
        wdata = keep_p;
      end
      PH_REST_B: begin
        we    = 1'b1;
        addr  = base;
        wdata = keep_b;
      end
      default: req = 1'b0;
    endcase
  end
endmodule

// File: rtl/msp_seq.sv
module msp_seq import msp_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 23,
  parameter int SIZE_W = 25,
  parameter int BSH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              hs,
  input  logic [DATA_W-1:0] rdata,
  input  logic [OFF_W-1:0]  offset,
  input  logic              first,
  input  logic              last,
  output phase_e            phase,
  output logic [ADDR_W-1:0] base_q,
  output logic [DATA_W-1:0] keep_p,
  output logic [DATA_W-1:0] keep_b,
  output logic              load,
  output logic              advance,
  output logic              done,
  output logic [SIZE_W-1:0] size_q
);
  localparam logic [SIZE_W-1:0] SIZE_FULL = SIZE_W'(1) << (SIZE_W - 1);

  logic              base_bad;
  logic [DATA_W-1:0] probe_val;
  logic              verdict;
  logic              mismatch;
  logic [SIZE_W-1:0] off_bytes;

  assign mismatch  = (probe_val != DATA_W'(offset));
  assign off_bytes = SIZE_W'(offset) << BSH;
  assign verdict   = (phase == PH_REST_B) && hs;
  assign load      = (phase == PH_IDLE) && start;
  assign advance   = verdict && !base_bad && !mismatch && !last;
  assign done      = (phase == PH_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      base_q    <= '0;
      keep_p    <= '0;
      keep_b    <= '0;
      base_bad  <= 1'b0;
      probe_val <= '0;
      size_q    <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          base_q <= base_in;
          phase  <= PH_SAVE_P;
        end
        PH_SAVE_P: if (hs) begin
          keep_p <= rdata;
          phase  <= PH_SAVE_B;
        end
        PH_SAVE_B: if (hs) begin
          keep_b <= rdata;
          phase  <= PH_MARK_P;
        end
        PH_MARK_P:  if (hs) phase <= PH_CLEAR_B;
        PH_CLEAR_B: if (hs) phase <= PH_TEST_B;
        PH_TEST_B: if (hs) begin
          base_bad <= (rdata != '0);
          phase    <= (rdata != '0) ? PH_REST_P : PH_READ_P1;
        end
        PH_READ_P1: if (hs) phase <= PH_READ_P2;
        PH_READ_P2: if (hs) begin
          probe_val <= rdata;
          phase     <= PH_REST_P;
        end
        PH_REST_P: if (hs) phase <= PH_REST_B;
        PH_REST_B: if (hs) begin
          if (base_bad) begin
            size_q <= '0;
            phase  <= PH_DONE;
          end else if (mismatch) begin
            size_q <= first ? '0 : off_bytes;
            phase  <= PH_DONE;
          end else if (last) begin
            size_q <= SIZE_FULL;
            phase  <= PH_DONE;
          end else begin
            phase <= PH_SAVE_P;
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msize_probe.sv
module msize_probe import msp_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int MAX_BYTES = 16777216
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [ADDR_W-1:0]              base_addr,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [ADDR_W-1:0]              mem_addr,
  output logic [DATA_W-1:0]              mem_wdata,
  input  logic [DATA_W-1:0]              mem_rdata,
  input  logic                           mem_ready,
  output logic                           done,
  output logic [$clog2(MAX_BYTES):0]     size_bytes
);
  localparam int WB          = DATA_W / 8;
  localparam int BSH         = $clog2(WB);
  localparam int START_WORDS = (1 << 20) / WB;
  localparam int MAX_WORDS   = MAX_BYTES / WB;
  localparam int OFF_W       = $clog2(MAX_WORDS) + 1;
  localparam int SIZE_W      = $clog2(MAX_BYTES) + 1;

  phase_e            phase;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] keep_p, keep_b;
  logic [OFF_W-1:0]  offset;
  logic              first, last, load, advance, hs;

  assign hs = mem_req && mem_ready;

  msp_offset_ctr #(
    .OFF_W(OFF_W), .START_WORDS(START_WORDS), .MAX_WORDS(MAX_WORDS)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .offset(offset), .first(first), .last(last)
  );

  msp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W), .BSH(BSH)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_addr),
    .hs(hs), .rdata(mem_rdata), .offset(offset), .first(first), .last(last),
    .phase(phase), .base_q(base_q), .keep_p(keep_p), .keep_b(keep_b),
    .load(load), .advance(advance), .done(done), .size_q(size_bytes)
  );

  msp_port_drv #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
  ) u_drv (
    .phase(phase), .base(base_q), .offset(offset),
    .keep_p(keep_p), .keep_b(keep_b),
    .req(mem_req), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata)
  );
endmodule

// File: rtl/msize_probe_chk.sv
module msize_probe_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int MAX_BYTES = 16777216
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       mem_req,
  input logic                       mem_we,
  input logic [ADDR_W-1:0]          mem_addr,
  input logic [DATA_W-1:0]          mem_wdata,
  input logic                       mem_ready,
  input logic                       done,
  input logic [$clog2(MAX_BYTES):0] size_bytes
);
  localparam int SIZE_W = $clog2(MAX_BYTES) + 1;
  localparam logic [SIZE_W-1:0] SIZE_MAX = SIZE_W'(MAX_BYTES);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R6
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready && mem_we |=> $stable(mem_wdata)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R7
  AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(size_bytes)); // R7
  AST_SIZE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(size_bytes) <= 1) && (size_bytes <= SIZE_MAX)); // R3
  AST_START_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start && done |=> !mem_req); // R8
  AST_STEP_OPENS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> !mem_we); // R1
endmodule

bind msize_probe msize_probe_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .done(done), .size_bytes(size_bytes)
);

// File: tb/tb_msize_probe.sv
`timescale 1ns/1ps
module tb_msize_probe;
  localparam int DW   = 32;
  localparam int AW   = 32;
  localparam int MAXB = 16777216;
  localparam int WB   = DW / 8;
  localparam int STW  = (1 << 20) / WB;
  localparam int MXW  = MAXB / WB;
  localparam int SW   = $clog2(MAXB) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ready = 1'b0;
  logic          done;
  logic [SW-1:0] size_bytes;

  msize_probe #(.DATA_W(DW), .ADDR_W(AW), .MAX_BYTES(MAXB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .done(done), .size_bytes(size_bytes)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // memory model configuration
  int unsigned   depth_w = 1 << 23;
  int            drop_bit = -1;
  logic [DW-1:0] stuck = '0;
  int            rmode = 0;
  logic [15:0]   lf = 16'hACE1;
  logic [DW-1:0] mem[int unsigned];
  logic [DW-1:0] shd[int unsigned];

  typedef struct { bit we; logic [AW-1:0] addr; logic [DW-1:0] data; } acc_t;
  acc_t expq[$];

  logic          p_req = 1'b0, p_rdy = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_wdata = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int unsigned phys(input logic [AW-1:0] a);
    logic [AW-1:0] t = a;
    if (drop_bit >= 0) t[drop_bit] = 1'b0;
    return t % depth_w;
  endfunction

  function automatic logic [DW-1:0] init_val(input int unsigned k);
    return (k * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [DW-1:0] m_rd(input logic [AW-1:0] a);
    int unsigned k = phys(a);
    return (mem.exists(k) ? mem[k] : init_val(k)) | stuck;
  endfunction

  function automatic logic [DW-1:0] s_rd(input logic [AW-1:0] a);
    int unsigned k = phys(a);
    return (shd.exists(k) ? shd[k] : init_val(k)) | stuck;
  endfunction

  function automatic void s_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    shd[phys(a)] = d;
  endfunction

  function automatic void push(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    acc_t e;
    e.we = we; e.addr = a; e.data = d;
    expq.push_back(e);
  endfunction

  // behavioural reference: expected access list and expected size
  function automatic longint ref_run(input logic [AW-1:0] b);
    longint off = STW;
    logic [DW-1:0] sp, sb, v;
    logic [AW-1:0] p;
    while (off < MXW) begin
      p = b + AW'(off);
      sp = s_rd(p); push(0, p, 0);
      sb = s_rd(b); push(0, b, 0);
      s_wr(p, DW'(off)); push(1, p, DW'(off));
      s_wr(b, 0);        push(1, b, 0);
      v = s_rd(b);       push(0, b, 0);
      if (v != 0) begin
        s_wr(p, sp); push(1, p, sp);
        s_wr(b, sb); push(1, b, sb);
        return 0;
      end
      push(0, p, 0);
      v = s_rd(p); push(0, p, 0);
      s_wr(p, sp); push(1, p, sp);
      s_wr(b, sb); push(1, b, sb);
      if (v != DW'(off)) return (off == STW) ? 0 : off * WB;
      off = off * 2;
    end
    return MAXB;
  endfunction

  // memory port model, acting between edges
  always @(negedge clk) begin
    bit rdy;
    acc_t e;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    rdy = (rmode == 0) ? 1'b1 : (lf[0] | lf[5]);
    if (rst_n) begin
      if (p_req && !p_rdy)
        chk(mem_req && mem_we == p_we && mem_addr == p_addr &&
            (!p_we || mem_wdata == p_wdata), "R6", "request held under back-pressure",
            longint'(mem_addr), longint'(p_addr));
      if (mem_req && rdy) begin
        if (expq.size() == 0) begin
          chk(0, "R1", "unexpected access at addr", longint'(mem_addr), 0);
        end else begin
          e = expq.pop_front();
          chk(mem_we == e.we && mem_addr == e.addr && (!e.we || mem_wdata == e.data),
              "R1", "access we/addr/data", {31'd0, mem_we, mem_addr},
              {31'd0, e.we, e.addr});
          if (e.we && mem_wdata != e.data)
            chk(0, "R2", "write data", longint'(mem_wdata), longint'(e.data));
        end
        if (mem_we) mem[phys(mem_addr)] = mem_wdata;
        else mem_rdata = m_rd(mem_addr);
      end
    end
    mem_ready = rdy;
    p_req = mem_req; p_rdy = rdy; p_we = mem_we;
    p_addr = mem_addr; p_wdata = mem_wdata;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(0, "R1", "watchdog expired, cycles", cyc, 0);
      summary();
    end
  end

  task automatic run_case(input string name, input int unsigned dep, input int drop,
                          input logic [DW-1:0] stk, input logic [AW-1:0] b,
                          input int rm, input bit kick_mid, input bit kick_done,
                          input string rq);
    longint expsz;
    logic [SW-1:0] held;
    bit quiet;
    bit same;
    mem.delete(); shd.delete(); expq.delete();
    depth_w = dep; drop_bit = drop; stuck = stk; rmode = rm;
    expsz = ref_run(b);
    @(negedge clk);
    base_addr = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; base_addr = '1;
    if (kick_mid) begin
      repeat (6) @(negedge clk);
      start = 1'b1;                       // R8: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    do @(negedge clk); while (!done);
    chk(longint'(size_bytes) == expsz, rq, {name, " size"}, longint'(size_bytes), expsz);
    chk(!mem_req, "R7", {name, " no request with done"}, mem_req, 0);
    held = size_bytes;
    if (kick_done) start = 1'b1;          // R8: start in the done cycle
    @(negedge clk);
    start = 1'b0;
    chk(!done && size_bytes == held, "R7", {name, " done one cycle, size held"},
        longint'(size_bytes), longint'(held));
    chk(expq.size() == 0, "R1", {name, " all expected accesses seen"}, expq.size(), 0);
    if (kick_done) begin
      quiet = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (mem_req || done) quiet = 1'b0;
      end
      chk(quiet, "R8", {name, " start during done ignored"}, quiet, 1);
    end
    if (stk == 0) begin
      same = 1'b1;
      foreach (mem[k]) if (mem[k] !== init_val(k)) same = 1'b0;
      chk(same, "R5", {name, " memory restored"}, same, 1);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!mem_req && !done, "R9", "outputs low in reset", {mem_req, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !done, "R9", "outputs low after reset", {mem_req, done}, 0);
    chk(size_bytes == 0, "R9", "size zero after reset", longint'(size_bytes), 0);
    // full-size memory, every step passes
    run_case("full", 1 << 23, -1, '0, 32'h0, 0, 1'b0, 1'b1, "R4");
    // 4 MiB memory wraps at the third step
    run_case("wrap4M", 1 << 20, -1, '0, 32'h0, 1, 1'b0, 1'b0, "R3");
    // 512 KiB memory aliases on the first step: size 0
    run_case("tiny", 1 << 17, -1, '0, 32'h0, 1, 1'b0, 1'b0, "R3");
    // stuck data bit: base never reads zero
    run_case("stuck", 1 << 23, -1, 32'h0000_0100, 32'h0, 1, 1'b0, 1'b0, "R2");
    // shorted address bit 19 (2 MiB offset) with a nonzero base and a mid-run start
    run_case("short19", 1 << 23, 19, '0, 32'h0000_0010, 1, 1'b1, 1'b0, "R3");
    // full memory again under back-pressure, nonzero base
    run_case("fullbp", 1 << 23, -1, '0, 32'h0000_0100, 1, 1'b0, 1'b1, "R4");
    summary();
  end
endmodule